// File: doc/BRIEF.md
# Serial BCD to Excess-3 Converter

This block turns one decimal digit, presented as a serial stream of four bits with the least significant bit first, into its excess-3 form: the digit's value plus three. The stream is processed one bit per clock on cycles where the valid strobe is high. Each result bit appears in the same cycle as the bit it belongs to, so the converted word leaves the block in step with the incoming one and there is no pipeline delay.

Internally a Mealy machine keeps two things in D flip-flops. The first is the position of the current bit within the digit. The second is the carry of a serial addition of the constant three. Because the output depends on the present input as well as this state, the result bit is ready before the clock edge that consumes the input. After the last bit of a digit, the position and carry both clear, so the next digit starts from the initial state with no gap cycle.

Top module: `bcd_xs3_serial`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, the machine enters its initial state (bit position 0, carry 0). The first digit after reset converts correctly.
- R2: When `ser_vld` is high, `ser_out` is bit k of (digit + 3) in the same cycle, where k is the bit's position in the digit. Bit 0 is the first bit sent and is the least significant.
- R3: For the first bit of every digit, `ser_out` is the inverse of `ser_in`.
- R4: For each BCD digit 0 to 9, the four `ser_out` bits of the digit, collected with the least significant bit first, equal the digit plus three (3 to 12).
- R5: Cycles with `ser_vld` low neither advance the bit position nor change the carry. A digit whose bits are separated by idle cycles converts the same as one sent back to back.
- R6: Input codes 10 to 15 produce the low four bits of (code + 3). The carry out of the last bit is discarded, and the digit that follows converts correctly.
- R7: While `ser_vld` is low, `ser_out` is 0, whatever `ser_in` is.
- R8: A reset asserted partway through a digit drops the partial digit. The next bit sent is treated as bit 0 of a new digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial BCD data bit, least significant bit first |
| ser_vld | input | 1 | High when `ser_in` carries a bit to be consumed this cycle |
| ser_out | output | 1 | Excess-3 bit for the present input; 0 when not valid |

## Verification
The bench sends all ten digits back to back several times, so it covers the wrap from the last bit straight into bit 0 of the next digit. A machine that kept a stale carry or skipped the clear would corrupt the digit that follows. Idle cycles with `ser_in` held high are inserted between bits: a design that let an idle cycle advance the position would misalign the word, and one that did not gate the output would emit ones. Codes 10 to 15 carry out of the top bit, and a design that kept that carry would give the next digit one extra. A reset partway through a digit checks that a leftover position does not shift the following digit.

// File: rtl/bxs3_pkg.sv
package bxs3_pkg;

  // One step of a serial adder: sum and carry of three single bits.
  typedef struct packed {
    logic cout;
    logic sum;
  } add_step_t;

  function automatic add_step_t add_step(input logic a, input logic b, input logic cin);
    add_step_t r;
    r.sum  = a ^ b ^ cin;
    r.cout = (a & b) | (a & cin) | (b & cin);
    return r;
  endfunction

endpackage

// File: rtl/bxs3_pos_ctr.sv
module bxs3_pos_ctr #(
  parameter int DIGIT_W = 4,
  localparam int PW = (DIGIT_W > 1) ? $clog2(DIGIT_W) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [PW-1:0] pos,
  output logic          last
);

  localparam logic [PW-1:0] LAST_POS = PW'(DIGIT_W - 1);

  logic [PW-1:0] pos_q;

  assign last = (pos_q == LAST_POS);
  assign pos  = pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
    end else if (adv) begin
      if (last) pos_q <= '0;
      else      pos_q <= pos_q + 1'b1;
    end
  end

endmodule

// File: rtl/bxs3_add_cell.sv
module bxs3_add_cell
  import bxs3_pkg::*;
#(
  parameter int DIGIT_W = 4,
  parameter int OFFSET  = 3,
  localparam int PW = (DIGIT_W > 1) ? $clog2(DIGIT_W) : 1
) (
  input  logic [PW-1:0] pos,
  input  logic          cin,
  input  logic          din,
  output logic          sum,
  output logic          cout
);

  localparam logic [DIGIT_W-1:0] OFF_V = DIGIT_W'(OFFSET);

  logic      addend;
  add_step_t step;

  always_comb begin
    addend = 1'b0;
    for (int i = 0; i < DIGIT_W; i++) begin
      if (pos == PW'(i)) addend = OFF_V[i];
    end
    step = add_step(din, addend, cin);
    sum  = step.sum;
    cout = step.cout;
  end

endmodule

// File: rtl/bxs3_carry_reg.sv
module bxs3_carry_reg (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic last,
  input  logic carry_nx,
  output logic carry
);

  always_ff @(posedge clk) begin
    if (rst)       carry <= 1'b0;
    else if (adv)  carry <= last ? 1'b0 : carry_nx;
  end

endmodule

// File: rtl/bcd_xs3_serial.sv
module bcd_xs3_serial #(
  parameter int DIGIT_W = 4,
  parameter int OFFSET  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_in,
  input  logic ser_vld,
  output logic ser_out
);

  localparam int PW = (DIGIT_W > 1) ? $clog2(DIGIT_W) : 1;

  logic [PW-1:0] bit_pos;
  logic          last_bit;
  logic          carry_q;
  logic          sum_bit;
  logic          carry_nx;

  bxs3_pos_ctr #(.DIGIT_W(DIGIT_W)) u_pos (
    .clk  (clk),
    .rst  (rst),
    .adv  (ser_vld),
    .pos  (bit_pos),
    .last (last_bit)
  );

  bxs3_add_cell #(.DIGIT_W(DIGIT_W), .OFFSET(OFFSET)) u_add (
    .pos  (bit_pos),
    .cin  (carry_q),
    .din  (ser_in),
    .sum  (sum_bit),
    .cout (carry_nx)
  );

  bxs3_carry_reg u_cy (
    .clk      (clk),
    .rst      (rst),
    .adv      (ser_vld),
    .last     (last_bit),
    .carry_nx (carry_nx),
    .carry    (carry_q)
  );

  assign ser_out = ser_vld & sum_bit;

endmodule

// File: rtl/bxs3_check.sv
module bxs3_check #(
  parameter int DIGIT_W = 4,
  localparam int PW = (DIGIT_W > 1) ? $clog2(DIGIT_W) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          ser_in,
  input logic          ser_vld,
  input logic          ser_out,
  input logic [PW-1:0] pos,
  input logic          carry,
  input logic          last
);

  logic rst_d = 1'b0;
  always_ff @(posedge clk) rst_d <= rst;

  // R1 / R8: state is initial on the edge after reset was high
  always_ff @(posedge clk) begin
    if (rst_d) begin
      assert_reset_init_R1: assert (pos == '0 && carry == 1'b0)
        else $error("reset did not clear state");
    end
  end

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !ser_vld |-> !ser_out);

  assert_bit0_invert_R3: assert property (@(posedge clk) disable iff (rst)
    (ser_vld && pos == '0) |-> (ser_out == !ser_in));

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !ser_vld |=> ($stable(pos) && $stable(carry)));

  assert_advance_R5: assert property (@(posedge clk) disable iff (rst)
    (ser_vld && !last) |=> (pos == PW'($past(pos) + 1'b1)));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (ser_vld && last) |=> (pos == '0 && !carry));

  assert_no_carry_at_start_R6: assert property (@(posedge clk) disable iff (rst)
    (pos == '0) |-> !carry);

endmodule

bind bcd_xs3_serial bxs3_check #(.DIGIT_W(DIGIT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ser_in  (ser_in),
  .ser_vld (ser_vld),
  .ser_out (ser_out),
  .pos     (bit_pos),
  .carry   (carry_q),
  .last    (last_bit)
);

// File: tb/bcd_xs3_serial_test.sv
module bcd_xs3_serial_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_in = 1'b0;
  logic ser_vld = 1'b0;
  logic ser_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state: bits seen so far in this digit and their count
  int m_pos = 0;
  int m_acc = 0;

  always #5 clk = ~clk;

  bcd_xs3_serial uut (
    .clk(clk), .rst(rst), .ser_in(ser_in), .ser_vld(ser_vld), .ser_out(ser_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send_bit(input int b, input bit v, output bit got);
    int exp;
    @(negedge clk);
    ser_in = b[0];
    ser_vld = v;
    #1;
    if (v) exp = (((m_acc | (b << m_pos)) + 3) >> m_pos) & 1;
    else   exp = 0;
    got = ser_out;
    if (!v)             check(ser_out == exp[0], "R7 idle output", int'(ser_out), exp);
    else if (m_pos == 0) check(ser_out == exp[0], "R3 first bit", int'(ser_out), exp);
    else                check(ser_out == exp[0], "R2 serial bit", int'(ser_out), exp);
    @(posedge clk);
    if (v && !rst) begin
      m_acc = m_acc | (b << m_pos);
      m_pos++;
      if (m_pos == 4) begin
        m_pos = 0;
        m_acc = 0;
      end
    end
  endtask

  task automatic send_digit(input int d, input int gap, input string req);
    int word = 0;
    bit g;
    for (int i = 0; i < 4; i++) begin
      send_bit((d >> i) & 1, 1'b1, g);
      word = word | (int'(g) << i);
      for (int k = 0; k < gap; k++) send_bit(1, 1'b0, g);
    end
    check(word == ((d + 3) & 15), req, word, (d + 3) & 15);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    ser_vld = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_pos = 0;
    m_acc = 0;
  endtask

  initial begin
    bit g;
    do_reset();
    // R1: idle output after reset is 0, first digit converts
    #1;
    check(ser_out == 1'b0, "R1 reset output", int'(ser_out), 0);
    send_digit(6, 0, "R1 first digit after reset");

    // R4: all ten digits, three passes back to back
    for (int p = 0; p < 3; p++)
      for (int d = 0; d < 10; d++) send_digit(d, 0, "R4 word");

    // R5 / R7: idle cycles between bits, ser_in held high while idle
    send_digit(7, 2, "R5 word with gaps");
    send_digit(2, 1, "R5 word with gaps");
    send_digit(9, 3, "R5 word with gaps");

    // R6: codes above nine, each followed by a valid digit
    for (int d = 10; d < 16; d++) begin
      send_digit(d, 0, "R6 code above nine");
      send_digit(5, 0, "R6 digit after overflow");
    end

    // R8: reset partway through a digit
    send_bit(1, 1'b1, g);
    send_bit(1, 1'b1, g);
    do_reset();
    send_digit(4, 0, "R8 digit after mid-digit reset");
    send_bit(0, 1'b1, g);
    send_bit(1, 1'b1, g);
    send_bit(1, 1'b1, g);
    do_reset();
    send_digit(8, 0, "R8 digit after mid-digit reset");
    send_digit(0, 0, "R8 digit after mid-digit reset");

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule